// File: doc/BRIEF.md
# Complementary Half-Bridge PWM Stage

This block generates pulse-width modulated gate signals for three half-bridge switch pairs. One free-running up-counter sets the PWM period. Each pair has its own duty value that is compared against the counter, so all three pairs share one period and one phase reference but can have different duty cycles. In each pair the odd-numbered output drives the upper switch and carries the duty signal. The even-numbered output drives the lower switch.

Each pair runs in one of two modes. In complementary mode the lower output is the inverse of the upper one. A programmable dead time delays every rising edge, so the two switches of one leg are never on together. In independent mode both outputs follow the same duty comparison and no dead time is applied. Software programs the block through a simple single-cycle register write port.

Duty and period values are double-buffered and reach the comparators only when the counter restarts. The mode bits and the dead time take effect on the next clock.

Top module: `cpwm_stage`

## Requirements
- R1: While `rst_n` is low all outputs are 0, and the duty, period, mode bits and dead time all clear to 0. All pairs therefore start in complementary mode: one cycle after reset is released the outputs are 6'b010101 and stay so until new values are written.
- R2: The period counter counts 0, 1, ... up to the active period value and then returns to 0. The upper output of pair k is `pwm_o[2k+1]`. With zero dead time it is high in the cycle after a counter value that is below the active duty value of pair k.
- R3: In complementary mode the lower output of pair k, `pwm_o[2k]`, follows the inverse of the same duty comparison. Outside the dead-time gaps it is the opposite of `pwm_o[2k+1]`.
- R4: A duty value of 0 holds the upper output low for the whole period. A duty value greater than the active period holds it high for the whole period.
- R5: In complementary mode the two outputs of a pair are never high in the same cycle, including across mode and dead-time changes.
- R6: The dead time D is an 8-bit cycle count. In complementary mode each output rises D cycles after its partner has fallen, so the pair shows 2·D both-low cycles per period. D = 0 inserts no gap.
- R7: Mode bit k = 1 selects independent mode for pair k. In that mode both outputs equal the upper duty comparison, with no dead time. Mode bit k = 0 selects complementary mode.
- R8: Duty and period writes reach the comparators and the counter only on the clock edge where the counter returns to 0. Mode and dead-time writes act from the next clock edge.
- R9: Register addresses (`wr_data` right-aligned):
  - 0, 1, 2: duty of pairs 0, 1, 2 (12 bits).
  - 3: period (12 bits).
  - 4: mode bits, bits 2:0, bit k for pair k.
  - 5: dead time, bits 7:0.
  
  Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address (see R9) |
| wr_data | input | 12 | Write data, right-aligned |
| pwm_o | output | 6 | Gate outputs, odd = upper switch, even = lower switch of the same pair |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, an 8-bit dead time and three pairs. It programs periods of at most 100 counts, so every cycle of the run can be checked against a bench model. Short periods mean the counter restarts hundreds of times, so the buffered duty and period loading (R8) is exercised at many phases against writes that arrive mid-period. Random dead times of up to 7 cycles, together with random mode flips, drive the non-overlap and gap rules through the transitions where the two outputs of a pair are most likely to collide.

// File: rtl/cpwm_pkg.sv
// Package: shared register map helpers for the complementary PWM stage.
// Assumes duty registers occupy offsets 0..PAIRS-1 and the control
// registers follow directly after them.
package cpwm_pkg;

    // Offset of the period register for a given number of pairs.
    function automatic int unsigned ofs_period(input int unsigned pairs);
        return pairs;
    endfunction

    // Offset of the per-pair mode bit register.
    function automatic int unsigned ofs_mode(input int unsigned pairs);
        return pairs + 1;
    endfunction

    // Offset of the dead-time count register.
    function automatic int unsigned ofs_dead(input int unsigned pairs);
        return pairs + 2;
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
// Module: write-port register file.
// Duty and period each have a shadow copy, written by software, and an
// active copy, which is loaded only on the counter-wrap edge.
// Mode bits and dead time act directly.
// Assumes DT_W <= CNT_W and PAIRS <= CNT_W; unmapped addresses are ignored.
module cpwm_regs #(
    parameter int CNT_W  = 12,
    parameter int DT_W   = 8,
    parameter int PAIRS  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        wrap_i,
    output logic [PAIRS-1:0][CNT_W-1:0] duty_o,
    output logic [CNT_W-1:0]            period_o,
    output logic [PAIRS-1:0]            indep_o,
    output logic [DT_W-1:0]             dead_o
);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(cpwm_pkg::ofs_period(PAIRS));
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(cpwm_pkg::ofs_mode(PAIRS));
    localparam logic [ADDR_W-1:0] A_DEAD = ADDR_W'(cpwm_pkg::ofs_dead(PAIRS));

    logic [PAIRS-1:0][CNT_W-1:0] duty_sh;
    logic [CNT_W-1:0]            period_sh;

    // Capture software writes into the shadow and direct registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_sh   <= '0;
            period_sh <= '0;
            indep_o   <= '0;
            dead_o    <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < PAIRS; p++) begin
                if (wr_addr == ADDR_W'(p)) duty_sh[p] <= wr_data;
            end
            if (wr_addr == A_PER)  period_sh <= wr_data;
            if (wr_addr == A_MODE) indep_o   <= wr_data[PAIRS-1:0];
            if (wr_addr == A_DEAD) dead_o    <= wr_data[DT_W-1:0];
        end
    end

    // Move shadow values into the active set only when the counter restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o   <= '0;
            period_o <= '0;
        end else if (wrap_i) begin
            duty_o   <= duty_sh;
            period_o <= period_sh;
        end
    end

    // R8: active values never move between wraps
    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(duty_o));
    a_r8_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(period_o));

endmodule

// File: rtl/cpwm_timebase.sv
// Module: shared period counter.
// Counts up from 0 to the active period, then returns to 0.
// wrap_o marks the cycle whose clock edge restarts the count.
// Assumes period_i changes only on that same edge.
module cpwm_timebase #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    // Restart when the terminal count is reached or passed.
    always_comb wrap_o = (cnt_o >= period_i);

    // Advance or restart the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (wrap_o) cnt_o <= '0;
        else             cnt_o <= cnt_o + 1'b1;
    end

    // R2: counter stays within the period, restarts and steps by one
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= period_i);
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o >= period_i) |=> (cnt_o == '0));
    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o < period_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/cpwm_pair.sv
// Module: one half-bridge output pair.
// Compares the shared count with the pair's duty value and produces the
// upper (main) and lower gate signals.
// In complementary mode each output's rise waits until its request has
// been held for dead_i cycles. Any fall is immediate.
// Outputs are registered: one cycle behind the counter value.
module cpwm_pair #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             indep_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             hi_o,
    output logic             lo_o
);
    logic            level;
    logic            req_hi;
    logic            req_lo;
    logic [DT_W-1:0] hi_wait_q;
    logic [DT_W-1:0] lo_wait_q;

    // Duty comparison and per-mode output requests.
    always_comb begin
        level  = (cnt_i < duty_i);
        req_hi = level;
        req_lo = indep_i ? level : ~level;
    end

    // Count how long each request has been held, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_wait_q <= '0;
            lo_wait_q <= '0;
        end else begin
            hi_wait_q <= !req_hi ? '0 : ((hi_wait_q == '1) ? hi_wait_q : hi_wait_q + 1'b1);
            lo_wait_q <= !req_lo ? '0 : ((lo_wait_q == '1) ? lo_wait_q : lo_wait_q + 1'b1);
        end
    end

    // Register the gated outputs; once high, an output holds while requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= 1'b0;
            lo_o <= 1'b0;
        end else begin
            hi_o <= req_hi & (indep_i | hi_o | (hi_wait_q >= dead_i));
            lo_o <= req_lo & (indep_i | lo_o | (lo_wait_q >= dead_i));
        end
    end

    // R5: never both on after a complementary-mode edge
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !indep_i |=> !(hi_o && lo_o));
    // R7: independent mode drives both outputs alike
    a_r7_indep_follow: assert property (@(posedge clk) disable iff (!rst_n)
        indep_i |=> (hi_o == lo_o));
    // R6: with a nonzero dead time, the upper rise follows a low partner
    a_r6_hi_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i) && ($past(dead_i) != '0) && $rose(hi_o)) |-> $past(!lo_o));
    a_r6_lo_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i) && ($past(dead_i) != '0) && $rose(lo_o)) |-> $past(!hi_o));

endmodule

// File: rtl/cpwm_stage.sv
// Module: top of the complementary PWM stage.
// Ties the register file, the shared time base and one output pair per
// duty register together. Pair k drives pwm_o[2k+1] (upper switch) and
// pwm_o[2k] (lower switch).
// Assumes ADDR_W can hold PAIRS+2.
module cpwm_stage #(
    parameter int CNT_W  = 12,
    parameter int DT_W   = 8,
    parameter int PAIRS  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [2*PAIRS-1:0]   pwm_o
);
    logic [PAIRS-1:0][CNT_W-1:0] duty;
    logic [CNT_W-1:0]            period;
    logic [PAIRS-1:0]            indep;
    logic [DT_W-1:0]             dead;
    logic [CNT_W-1:0]            cnt;
    logic                        wrap;

    cpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .PAIRS(PAIRS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap_i(wrap), .duty_o(duty), .period_o(period), .indep_o(indep), .dead_o(dead)
    );

    cpwm_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .period_i(period), .cnt_o(cnt), .wrap_o(wrap)
    );

    // One output pair per duty register.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) pair_i (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .duty_i(duty[k]),
            .indep_i(indep[k]), .dead_i(dead),
            .hi_o(pwm_o[2*k+1]), .lo_o(pwm_o[2*k])
        );
    end

endmodule

// File: tb/cpwm_stage_tb_top.sv
`timescale 1ns/1ps
module cpwm_stage_tb_top;
    localparam int CNT_W = 12, DT_W = 8, PAIRS = 3, ADDR_W = 3, NOUT = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  wr_data;
    logic [NOUT-1:0]   pwm_o;

    cpwm_stage #(.CNT_W(CNT_W), .DT_W(DT_W), .PAIRS(PAIRS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string tag     = "R1";

    // Bench model state, derived from the requirements.
    int       m_cnt, m_per_s, m_per_a, m_dt;
    int       m_duty_s[3], m_duty_a[3], m_hw[3], m_lw[3];
    bit [2:0] m_mode, m_mode_used;
    bit [5:0] m_out;
    int       acc_hi[6], acc_gap[3], acc_diff[3];

    function automatic bit duty_level(int cnt, int duty);
        return cnt < duty;
    endfunction

    function automatic int sat_inc(int v);
        return (v >= 255) ? 255 : v + 1;
    endfunction

    task automatic check(string t, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_per_s = 0; m_per_a = 0; m_dt = 0;
        m_mode = 0; m_mode_used = 0; m_out = 0;
        for (int p = 0; p < 3; p++) begin
            m_duty_s[p] = 0; m_duty_a[p] = 0; m_hw[p] = 0; m_lw[p] = 0;
        end
    endtask

    // Advance the model by one clock edge, using the inputs now driven.
    task automatic model_step();
        bit [5:0] nxt;
        bit wrap;
        wrap = (m_cnt >= m_per_a);
        for (int p = 0; p < 3; p++) begin
            bit lv, rh, rl;
            lv = duty_level(m_cnt, m_duty_a[p]);
            rh = lv;
            rl = m_mode[p] ? lv : !lv;
            nxt[2*p+1] = rh && (m_mode[p] || m_out[2*p+1] || m_hw[p] >= m_dt);
            nxt[2*p]   = rl && (m_mode[p] || m_out[2*p]   || m_lw[p] >= m_dt);
            m_hw[p] = rh ? sat_inc(m_hw[p]) : 0;
            m_lw[p] = rl ? sat_inc(m_lw[p]) : 0;
        end
        m_mode_used = m_mode;
        if (wrap) begin
            m_per_a = m_per_s;
            for (int p = 0; p < 3; p++) m_duty_a[p] = m_duty_s[p];
            m_cnt = 0;
        end else begin
            m_cnt = m_cnt + 1;
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0, 3'd1, 3'd2: m_duty_s[wr_addr] = int'(wr_data);
                3'd3: m_per_s = int'(wr_data);
                3'd4: m_mode  = wr_data[2:0];
                3'd5: m_dt    = int'(wr_data[7:0]);
                default: ;
            endcase
        end
        m_out = nxt;
    endtask

    // Check this cycle's outputs, accumulate statistics, then advance one cycle.
    task automatic step();
        check({tag, " outputs"}, int'(pwm_o), int'(m_out));
        for (int p = 0; p < 3; p++) begin
            if (!m_mode_used[p])
                check("R5 pair overlap", int'(pwm_o[2*p+1] & pwm_o[2*p]), 0);
            if (!pwm_o[2*p+1] && !pwm_o[2*p]) acc_gap[p]++;
            if (pwm_o[2*p+1] != pwm_o[2*p])   acc_diff[p]++;
        end
        for (int i = 0; i < 6; i++) if (pwm_o[i]) acc_hi[i]++;
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic measure(int n);
        for (int i = 0; i < 6; i++) acc_hi[i] = 0;
        for (int p = 0; p < 3; p++) begin acc_gap[p] = 0; acc_diff[p] = 0; end
        idle(n);
    endtask

    initial begin
        void'($urandom(32'd715));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and complementary default
        tag = "R1 reset";
        check("R1 outputs in reset", int'(pwm_o), 0);
        idle(2);
        check("R1 complementary default", int'(pwm_o), 6'b010101);

        // R9 setup, R2/R3/R4/R6 measured over one full period of 100 counts
        tag = "R9 setup";
        wr(3, 99); wr(0, 50); wr(1, 0); wr(2, 200); wr(5, 5);
        idle(250);
        tag = "R2 R6 steady";
        measure(100);
        check("R2 pair0 main high cycles", acc_hi[1], 45);
        check("R3 pair0 complement high cycles", acc_hi[0], 45);
        check("R6 pair0 both-low cycles dead=5", acc_gap[0], 10);
        check("R4 duty zero main", acc_hi[3], 0);
        check("R4 duty zero complement", acc_hi[2], 100);
        check("R4 duty above period main", acc_hi[5], 100);
        check("R4 duty above period complement", acc_hi[4], 0);

        // R6: zero dead time means no gap
        wr(5, 0);
        idle(10);
        tag = "R6 zero dead";
        measure(100);
        check("R6 no gap with dead=0", acc_gap[0], 0);
        check("R2 main high cycles dead=0", acc_hi[1], 50);
        check("R3 complement disagrees every cycle", acc_diff[0], 100);

        // R8: a mid-period duty write is deferred to the wrap
        tag = "R8 deferred";
        while (m_cnt != 60) step();
        wr(0, 80);
        idle(10);
        check("R8 old duty still in force", int'(pwm_o[1]), 0);
        idle(120);
        measure(100);
        check("R8 new duty after wrap", acc_hi[1], 80);

        // R7: independent mode on pair 0 only
        tag = "R7 independent";
        wr(4, 1);
        idle(5);
        measure(100);
        check("R7 even equals odd", acc_diff[0], 0);
        check("R7 even follows duty", acc_hi[0], 80);
        check("R7 other pair stays complementary", acc_hi[2], 100);

        // R9: unmapped addresses have no effect
        tag = "R9 unmapped";
        wr(6, 4095); wr(7, 0);
        idle(3);
        measure(100);
        check("R9 pair0 unchanged", acc_hi[1], 80);
        check("R9 pair1 unchanged", acc_hi[3], 0);
        check("R9 pair2 unchanged", acc_hi[5], 100);

        // R2 R3 R5 R6 R7 R8 under random writes at random phases
        tag = "R2 R3 R6 R8 random";
        wr(4, 0);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 10 == 0) begin
                int a, d;
                a = int'($urandom % 8);
                case (a)
                    0, 1, 2: d = int'($urandom % 48);
                    3:       d = int'($urandom % 40);
                    4, 5:    d = int'($urandom % 8);
                    default: d = int'($urandom % 4096);
                endcase
                wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
            end else begin
                wr_en = 1'b0;
            end
            step();
        end
        wr_en = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule